// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This block turns a process-relative (logical) address into a physical address. It uses two registers: a relocation base and a bound. Each request arrives with a strobe. The logical address is first checked against the bound. Only a legal address gets the base added to it. An illegal one raises a protection trap, and no physical address is issued. The result appears one clock after the request.

The operating system loads the base and bound registers on a context switch through a write port, and only a privileged write takes effect. A write attempted from user mode is dropped and produces a one-cycle privilege-fault pulse. A mode input selects how the bound is read:

- **Size mode:** the bound is the size of the process image.
- **End mode:** the bound is the last physical address the process may touch.

Moving a process needs nothing more than a new base; its logical addresses stay the same.

The response path is a three-state machine. `RSP_IDLE` means no response this cycle, `RSP_PASS` means a translated address is being presented, and `RSP_TRAP` means a protection trap is being presented. On every clock it moves:

- to `RSP_PASS` when a legal request is present;
- to `RSP_TRAP` when an illegal request is present;
- to `RSP_IDLE` when no request is present.

Any state can reach any other in one step, and reset forces `RSP_IDLE`.

Top module: `relo_unit`

## Requirements
- R1: With `limit_is_end` = 0 (size mode), a request is legal only when the zero-extended logical address is strictly less than the bound, so an address equal to the bound traps. A legal request yields physical address = base + logical address.
- R2: With `limit_is_end` = 1 (end mode), a request is legal only when base + logical address is less than or equal to the bound. An address landing exactly on the bound passes.
- R3: If base + logical address does not fit in `PADDR_W` bits, the request traps in either mode; it never wraps.
- R4: A trapped request shows `out_trap` = 1, `out_valid` = 0 and `out_paddr` = 0. `out_valid` and `out_trap` are never high together.
- R5: The response to a request on clock edge n is presented after edge n+1 and lasts one cycle. In a cycle after an edge with no request, both `out_valid` and `out_trap` are 0.
- R6: A write with `cfg_we` = 1 and `cfg_priv` = 1 loads `cfg_wdata` into the base when `cfg_sel` = 0, or into the bound when `cfg_sel` = 1. The new value governs requests from the following edge onward. A request in the same cycle as the write uses the old values.
- R7: A write with `cfg_we` = 1 and `cfg_priv` = 0 changes neither register. It drives `priv_fault` high for exactly the one cycle that follows.
- R8: After reset the base and bound are 0, and `out_valid`, `out_trap` and `priv_fault` are 0. In size mode every request then traps.
- R9: After a privileged change of the base alone, the same logical address translates to the new base plus that address, with no change to the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | LADDR_W | Logical address of the request |
| limit_is_end | input | 1 | 0: bound is a size; 1: bound is an end address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 bound |
| cfg_priv | input | 1 | 1 when the issuing core is in privileged mode |
| cfg_wdata | input | PADDR_W | Value to load |
| out_valid | output | 1 | Translated address is present |
| out_trap | output | 1 | Protection trap for the request |
| out_paddr | output | PADDR_W | Physical address, 0 unless `out_valid` |
| priv_fault | output | 1 | One-cycle pulse after a user-mode write attempt |

## Verification
Translation and register loading can land in the same cycle. A request may arrive on the same edge as a privileged write to the base or the bound, or as a rejected user-mode write. The directed part of the bench forces such collisions. It also leaves the random stream free to produce them. Each response is judged against a reference model whose base and bound are updated only after that cycle's expected result has been formed. A same-cycle write must therefore not affect that cycle's request, must govern the next one, and in user mode must still raise the fault pulse.

// File: rtl/relo_pkg.sv
package relo_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_PASS = 2'd1,
        RSP_TRAP = 2'd2
    } rsp_state_e;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_BOUND = 1'b1
    } cfg_sel_e;

    typedef enum logic {
        LIM_SIZE = 1'b0,
        LIM_END  = 1'b1
    } lim_mode_e;

endpackage

// File: rtl/relo_regs.sv
module relo_regs
    import relo_pkg::*;
#(
    parameter int PADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic               cfg_priv,
    input  logic [PADDR_W-1:0] cfg_wdata,
    output logic [PADDR_W-1:0] base_q,
    output logic [PADDR_W-1:0] bound_q,
    output logic               priv_fault
);

    logic wr_ok;
    logic wr_bad;

    assign wr_ok  = cfg_we &&  cfg_priv;
    assign wr_bad = cfg_we && !cfg_priv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            bound_q    <= '0;
            priv_fault <= 1'b0;
        end else begin
            priv_fault <= wr_bad;
            if (wr_ok) begin
                unique case (cfg_sel_e'(cfg_sel))
                    SEL_BASE:  base_q  <= cfg_wdata;
                    SEL_BOUND: bound_q <= cfg_wdata;
                    default:   base_q  <= base_q;
                endcase
            end
        end
    end

    AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> ($stable(base_q) && $stable(bound_q))); // R7
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> priv_fault); // R7
    AST_FAULT_ONLY_ON_USER: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !cfg_priv) |=> !priv_fault); // R7
    AST_PRIV_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_priv && !cfg_sel) |=> (base_q == $past(cfg_wdata))); // R6

endmodule

// File: rtl/relo_check.sv
module relo_check
    import relo_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int PADDR_W = 20
) (
    input  logic [LADDR_W-1:0] addr,
    input  logic [PADDR_W-1:0] base,
    input  logic [PADDR_W-1:0] bound,
    input  logic               mode_end,
    output logic               legal,
    output logic [PADDR_W-1:0] paddr
);

    localparam int EXT_W = PADDR_W - LADDR_W;
    localparam int SUM_W = PADDR_W + 1;

    logic [PADDR_W-1:0] addr_ext;
    logic [SUM_W-1:0]   sum;
    logic               carry;
    logic               size_ok;
    logic               end_ok;

    generate
        if (EXT_W > 0) begin : g_zext
            assign addr_ext = {{EXT_W{1'b0}}, addr};
        end else begin : g_same
            assign addr_ext = addr[PADDR_W-1:0];
        end
    endgenerate

    // Both comparisons run in parallel; the mode only picks one.
    assign sum     = {1'b0, base} + {1'b0, addr_ext};
    assign carry   = sum[PADDR_W];
    assign size_ok = addr_ext < bound;
    assign end_ok  = sum[PADDR_W-1:0] <= bound;

    always_comb begin
        unique case (lim_mode_e'(mode_end))
            LIM_SIZE: legal = size_ok && !carry;
            LIM_END:  legal = end_ok  && !carry;
            default:  legal = 1'b0;
        endcase
        paddr = legal ? sum[PADDR_W-1:0] : '0;
    end

endmodule

// File: rtl/relo_resp_fsm.sv
module relo_resp_fsm
    import relo_pkg::*;
#(
    parameter int PADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               legal,
    input  logic [PADDR_W-1:0] paddr_in,
    output logic               out_valid,
    output logic               out_trap,
    output logic [PADDR_W-1:0] out_paddr
);

    rsp_state_e         state_q;
    rsp_state_e         state_d;
    logic [PADDR_W-1:0] paddr_q;

    always_comb begin
        if (!req_valid)  state_d = RSP_IDLE;
        else if (legal)  state_d = RSP_PASS;
        else             state_d = RSP_TRAP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            paddr_q <= (state_d == RSP_PASS) ? paddr_in : '0;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_trap  = 1'b0;
        out_paddr = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_PASS: begin
                out_valid = 1'b1;
                out_paddr = paddr_q;
            end
            RSP_TRAP: out_trap = 1'b1;
            default:  ;
        endcase
    end

    AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_trap)); // R4
    AST_TRAP_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_paddr == '0)); // R4

endmodule

// File: rtl/relo_unit.sv
module relo_unit
    import relo_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int PADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LADDR_W-1:0] req_addr,
    input  logic               limit_is_end,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic               cfg_priv,
    input  logic [PADDR_W-1:0] cfg_wdata,
    output logic               out_valid,
    output logic               out_trap,
    output logic [PADDR_W-1:0] out_paddr,
    output logic               priv_fault
);

    localparam int EXT_W = PADDR_W - LADDR_W;

    logic [PADDR_W-1:0] base_q;
    logic [PADDR_W-1:0] bound_q;
    logic               legal;
    logic [PADDR_W-1:0] paddr_c;

    relo_regs #(.PADDR_W(PADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_priv   (cfg_priv),
        .cfg_wdata  (cfg_wdata),
        .base_q     (base_q),
        .bound_q    (bound_q),
        .priv_fault (priv_fault)
    );

    relo_check #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_check (
        .addr     (req_addr),
        .base     (base_q),
        .bound    (bound_q),
        .mode_end (limit_is_end),
        .legal    (legal),
        .paddr    (paddr_c)
    );

    relo_resp_fsm #(.PADDR_W(PADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .legal     (legal),
        .paddr_in  (paddr_c),
        .out_valid (out_valid),
        .out_trap  (out_trap),
        .out_paddr (out_paddr)
    );

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_valid || out_trap)); // R5
    AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_trap)); // R5
    AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !limit_is_end && ({{EXT_W{1'b0}}, req_addr} >= bound_q)) |=> out_trap); // R1
    AST_END_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && limit_is_end) |=> (out_trap || (out_paddr <= $past(bound_q)))); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_paddr >= $past(base_q))); // R3

endmodule

// File: tb/tb_relo_unit.sv
module tb_relo_unit;

    localparam int LW = 16;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [LW-1:0] req_addr = '0;
    logic          limit_is_end = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic          cfg_priv = 1'b0;
    logic [PW-1:0] cfg_wdata = '0;
    logic          out_valid;
    logic          out_trap;
    logic [PW-1:0] out_paddr;
    logic          priv_fault;

    int nchecks = 0;
    int nerr = 0;
    logic [PW-1:0] m_base = '0;
    logic [PW-1:0] m_bound = '0;

    always #10 clk = ~clk;

    relo_unit #(.LADDR_W(LW), .PADDR_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .limit_is_end(limit_is_end), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_priv(cfg_priv), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
        .out_trap(out_trap), .out_paddr(out_paddr), .priv_fault(priv_fault)
    );

    function automatic logic [PW:0] ref_sum(logic [PW-1:0] b, logic [LW-1:0] a);
        return {1'b0, b} + (PW+1)'(a);
    endfunction

    function automatic logic ref_legal(logic [PW-1:0] b, logic [PW-1:0] l,
                                       logic [LW-1:0] a, logic md);
        logic [PW:0] s;
        s = ref_sum(b, a);
        if (s[PW]) return 1'b0;
        if (md) return s[PW-1:0] <= l;
        return PW'(a) < l;
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic step(input logic rv, input logic [LW-1:0] a, input logic md,
                        input logic we, input logic sel, input logic pr,
                        input logic [PW-1:0] wd, input string tag);
        logic          e_ok;
        logic [PW-1:0] e_pa;
        logic          e_pf;
        e_ok = ref_legal(m_base, m_bound, a, md);
        e_pa = ref_sum(m_base, a)[PW-1:0];
        e_pf = we && !pr;
        req_valid = rv; req_addr = a; limit_is_end = md;
        cfg_we = we; cfg_sel = sel; cfg_priv = pr; cfg_wdata = wd;
        @(negedge clk);
        if (rv) begin
            chk(out_valid == e_ok, tag, "out_valid", 32'(out_valid), 32'(e_ok));
            chk(out_trap == !e_ok, e_ok ? tag : "R4", "out_trap", 32'(out_trap), 32'(!e_ok));
            chk(out_paddr == (e_ok ? e_pa : '0), e_ok ? tag : "R4", "out_paddr",
                32'(out_paddr), 32'(e_ok ? e_pa : '0));
        end else begin
            chk(!out_valid && !out_trap, "R5", "idle outputs",
                {30'd0, out_valid, out_trap}, 32'd0);
        end
        chk(priv_fault == e_pf, "R7", "priv_fault", 32'(priv_fault), 32'(e_pf));
        if (we && pr) begin
            if (sel) m_bound = wd; else m_base = wd;
        end
    endtask

    task automatic wr(input logic sel, input logic [PW-1:0] v);
        step(1'b0, '0, 1'b0, 1'b1, sel, 1'b1, v, "R6");
    endtask

    initial begin
        #(200000 * 20);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        logic [LW-1:0] ra;
        logic          rmd;
        logic          rwe;
        logic          rsel;
        logic          rpr;
        logic [PW-1:0] rwd;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!out_valid && !out_trap && !priv_fault, "R8", "reset outputs",
            {29'd0, out_valid, out_trap, priv_fault}, 32'd0);
        rst_n = 1'b1;
        // R8: bound is 0 after reset, so size mode traps everything
        step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8");
        // R7: user write to base is ignored and pulses the fault
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 20'h55555, "R7");
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R7");
        // R1: size-mode boundary
        wr(1'b1, 20'h00100);
        step(1'b1, 16'h00FF, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1");
        step(1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1");
        step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1");
        // R9: relocation by base alone
        wr(1'b0, 20'h01000);
        step(1'b1, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9");
        wr(1'b0, 20'h08000);
        step(1'b1, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9");
        chk(out_paddr == 20'h08010, "R9", "relocated paddr", 32'(out_paddr), 32'h08010);
        // R2: end-mode boundary
        wr(1'b1, 20'h08100);
        step(1'b1, 16'h0100, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R2");
        step(1'b1, 16'h0101, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R2");
        // R3: overflow traps, top address passes
        wr(1'b0, 20'hFFFF0);
        wr(1'b1, 20'hFFFFF);
        step(1'b1, 16'h000F, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R3");
        step(1'b1, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R3");
        step(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3");
        // R6: request in the same cycle as a base write uses the old base
        wr(1'b0, 20'h00200);
        step(1'b1, 16'h0004, 1'b0, 1'b1, 1'b0, 1'b1, 20'h30000, "R6");
        step(1'b1, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R6");
        // R7: user write colliding with a request
        step(1'b1, 16'h0004, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00000, "R7");
        step(1'b1, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R7");
        // R5: idle cycle
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R5");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            ra   = LW'($urandom);
            rmd  = 1'($urandom);
            rwe  = ($urandom % 6) == 0;
            rsel = 1'($urandom);
            rpr  = ($urandom % 4) != 0;
            if (($urandom % 3) == 0) rwd = PW'(20'hF0000 | PW'($urandom));
            else                     rwd = PW'($urandom);
            step(($urandom % 5) != 0, ra, rmd, rwe, rsel, rpr, rwd,
                 ref_sum(m_base, ra)[PW] ? "R3" : (rmd ? "R2" : "R1"));
        end
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule